// File: doc/BRIEF.md
# Word-Port Cipher Data Buffer

This block is the processor-side data path of a block cipher engine that is fed by program-controlled word transfers rather than by a DMA engine. Software pushes 32-bit words into an input port. Four of them make up one 128-bit block. Once the block is complete, it is handed to the engine. The engine's result lands in a one-block output buffer, and software pulls it out one 32-bit word at a time through an output port. A status word reports whether each buffer is empty or full. Misuse of either port is latched in sticky error bits rather than being lost. Each port can reverse the byte order of every word independently.

In this project the cipher core is a stub: a three-state machine with states Idle, Crunch and Park. In Idle, once the input buffer holds a full block, it takes that block (Idle to Crunch) and XORs it with a fixed mask. It stays in Crunch for LAT cycles and then moves to Park (Crunch to Park). In Park it waits until the output buffer is empty, then deposits its result (Park to Idle). Each deposit raises the finish interrupt flag. Either kind of misuse raises the error interrupt flag. Both flags are cleared by writing 1 and have their own enables, and the interrupt line is the OR of each enabled flag.

Top module: `wordport_cbuf`

## Requirements
- R1: After reset the status word is 0x0001_0100: input empty (bit 8) and output empty (bit 16) are set, and all other bits are 0. Both interrupt flags and the interrupt line are 0.
- R2: Each accepted write stores one word. Word k goes into bits [32k+31:32k] of the block, for k = 0..3. Input full (bit 9) is set once four words are held, and input empty (bit 8) is set when none are held. A block with fewer than four words is never taken by the engine.
- R3: A write while the input buffer is full sets the sticky input error bit (bit 10) and is discarded. The buffered block is unchanged.
- R4: The result is the input block XOR the MASK parameter. It is read out low word first. Output full (bit 17) is set while all four words are unread, and output empty (bit 16) is set when none remain.
- R5: A read while the output buffer is empty returns 0 and sets the sticky output error bit (bit 18).
- R6: While the output buffer still holds unread words, the engine does not overwrite it. A finished result waits in the engine, and a further complete block waits in the input buffer.
- R7: When in_swap is 1, each written word {b3,b2,b1,b0} is stored as {b0,b1,b2,b3}. When out_swap is 1, each read word is reversed the same way. The two settings are independent.
- R8: Finish flag irq_flags[0] is set in the cycle a result is deposited into the output buffer.
- R9: Error flag irq_flags[1] is set by any overrun or underrun. Writing 1 to an irq_clr bit clears the corresponding flag, and writing 0 has no effect. Clearing irq_flags[1] also clears status bits 10 and 18. A new event in the same cycle takes priority over the clear.
- R10: irq is 1 exactly when some flag is set together with its irq_en bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the input port |
| wr_data | input | 32 | Word written to the input port |
| in_swap | input | 1 | Reverse byte order of written words |
| rd_en | input | 1 | Read strobe for the output port |
| rd_data | output | 32 | Current output word; 0 when the output buffer is empty |
| out_swap | input | 1 | Reverse byte order of read words |
| irq_en | input | 2 | Enables for finish (bit 0) and error (bit 1) flags |
| irq_clr | input | 2 | Write-one-to-clear strobes for the two flags |
| stat_word | output | 32 | Buffer status and sticky error bits |
| irq_flags | output | 2 | Finish (bit 0) and error (bit 1) interrupt flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong word count in the input buffer shows at the ports within one clock. The full and empty bits disagree with the number of writes, or a short block reaches the output. A wrong read index shows as words that are out of order or repeated on the very next read. An engine that ignores a full output buffer corrupts the unread block. This is visible only when the block is drained, so the bench holds three blocks in flight and reads each one back in full. Swap or mask faults show in every word of the sweep over all four swap combinations.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTES  = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_CRUNCH,
        ENG_PARK
    } eng_state_t;

    function automatic word_t byte_rev(input word_t w);
        word_t r;
        for (int i = 0; i < int'(BYTES); i++) begin
            r[8*i +: 8] = w[8*(int'(BYTES)-1-i) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wcb_in_buf.sv
module wcb_in_buf
    import wcb_pkg::*;
#(
    parameter int unsigned WORDS = 4,
    localparam int unsigned CW = $clog2(WORDS + 1),
    localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  word_t                    wr_data,
    input  logic                     swap_en,
    input  logic                     take,
    output logic [WORDS*WORD_W-1:0]  blk,
    output logic                     full,
    output logic                     empty,
    output logic                     overrun
);
    logic [CW-1:0] cnt;
    word_t         mem [WORDS];

    assign full    = (cnt == CW'(WORDS));
    assign empty   = (cnt == '0);
    assign overrun = wr_en && full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= '0;
        end else if (wr_en && !full) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !full && !take) begin
            mem[cnt[IW-1:0]] <= swap_en ? byte_rev(wr_data) : wr_data;
        end
    end

    for (genvar g = 0; g < int'(WORDS); g++) begin : g_pack
        assign blk[g*WORD_W +: WORD_W] = mem[g];
    end
endmodule

// File: rtl/wcb_out_buf.sv
module wcb_out_buf
    import wcb_pkg::*;
#(
    parameter int unsigned WORDS = 4,
    localparam int unsigned CW = $clog2(WORDS + 1),
    localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [WORDS*WORD_W-1:0]  load_blk,
    input  logic                     rd_en,
    input  logic                     swap_en,
    output word_t                    rd_data,
    output logic                     full,
    output logic                     empty,
    output logic                     underrun
);
    logic [CW-1:0]           cnt;
    logic [CW-1:0]           idx;
    logic [WORDS*WORD_W-1:0] hold;
    word_t                   cur;

    assign full     = (cnt == CW'(WORDS));
    assign empty    = (cnt == '0);
    assign underrun = rd_en && empty;
    assign idx      = CW'(WORDS) - cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(WORDS);
        end else if (rd_en && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            hold <= load_blk;
        end
    end

    always_comb begin
        cur     = hold[idx[IW-1:0]*WORD_W +: WORD_W];
        rd_data = empty ? '0 : (swap_en ? byte_rev(cur) : cur);
    end
endmodule

// File: rtl/wcb_engine_stub.sv
module wcb_engine_stub
    import wcb_pkg::*;
#(
    parameter int unsigned BLK_W = 128,
    parameter int unsigned LAT   = 3,
    parameter logic [BLK_W-1:0] MASK = '0,
    localparam int unsigned TW = $clog2(LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_full,
    input  logic [BLK_W-1:0] in_blk,
    input  logic             out_empty,
    output logic             take,
    output logic             load,
    output logic [BLK_W-1:0] out_blk
);
    eng_state_t     st, st_nx;
    logic [TW-1:0]  timer;
    logic [BLK_W-1:0] work;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ENG_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        take  = 1'b0;
        load  = 1'b0;
        unique case (st)
            ENG_IDLE: begin
                if (in_full) begin
                    take  = 1'b1;
                    st_nx = ENG_CRUNCH;
                end
            end
            ENG_CRUNCH: begin
                if (timer == '0) st_nx = ENG_PARK;
            end
            ENG_PARK: begin
                if (out_empty) begin
                    load  = 1'b1;
                    st_nx = ENG_IDLE;
                end
            end
            default: st_nx = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (take) begin
            timer <= TW'(LAT - 1);
        end else if (st == ENG_CRUNCH && timer != '0) begin
            timer <= timer - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) work <= in_blk ^ MASK;
    end

    assign out_blk = work;
endmodule

// File: rtl/wcb_flags.sv
module wcb_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done_set,
    input  logic       in_ovr,
    input  logic       out_und,
    input  logic [1:0] clr,
    input  logic [1:0] en,
    output logic [1:0] flags,
    output logic       in_err,
    output logic       out_err,
    output logic       irq
);
    logic err_set;
    assign err_set = in_ovr | out_und;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            in_err  <= 1'b0;
            out_err <= 1'b0;
        end else begin
            flags[0] <= done_set | (flags[0] & ~clr[0]);
            flags[1] <= err_set  | (flags[1] & ~clr[1]);
            in_err   <= in_ovr   | (in_err   & ~clr[1]);
            out_err  <= out_und  | (out_err  & ~clr[1]);
        end
    end

    assign irq = |(flags & en);
endmodule

// File: rtl/wordport_cbuf.sv
module wordport_cbuf
    import wcb_pkg::*;
#(
    parameter int unsigned WORDS = 4,
    parameter int unsigned LAT   = 3,
    parameter logic [WORDS*wcb_pkg::WORD_W-1:0] MASK = {WORDS{32'h5A5A_A5A5}}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        in_swap,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        out_swap,
    input  logic [1:0]  irq_en,
    input  logic [1:0]  irq_clr,
    output logic [31:0] stat_word,
    output logic [1:0]  irq_flags,
    output logic        irq
);
    localparam int unsigned BLK_W = WORDS * WORD_W;

    logic [BLK_W-1:0] in_blk, res_blk;
    logic in_full, in_empty, in_ovr;
    logic out_full, out_empty, out_und;
    logic take, load, in_err, out_err;

    wcb_in_buf #(.WORDS(WORDS)) u_in (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .swap_en(in_swap), .take(take), .blk(in_blk),
        .full(in_full), .empty(in_empty), .overrun(in_ovr)
    );

    wcb_engine_stub #(.BLK_W(BLK_W), .LAT(LAT), .MASK(MASK)) u_eng (
        .clk(clk), .rst_n(rst_n), .in_full(in_full), .in_blk(in_blk),
        .out_empty(out_empty), .take(take), .load(load), .out_blk(res_blk)
    );

    wcb_out_buf #(.WORDS(WORDS)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .load_blk(res_blk),
        .rd_en(rd_en), .swap_en(out_swap), .rd_data(rd_data),
        .full(out_full), .empty(out_empty), .underrun(out_und)
    );

    wcb_flags u_flg (
        .clk(clk), .rst_n(rst_n), .done_set(load), .in_ovr(in_ovr),
        .out_und(out_und), .clr(irq_clr), .en(irq_en), .flags(irq_flags),
        .in_err(in_err), .out_err(out_err), .irq(irq)
    );

    always_comb begin
        stat_word     = '0;
        stat_word[8]  = in_empty;
        stat_word[9]  = in_full;
        stat_word[10] = in_err;
        stat_word[16] = out_empty;
        stat_word[17] = out_full;
        stat_word[18] = out_err;
    end
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] rd_data,
    input logic [31:0] stat_word,
    input logic [1:0]  irq_clr,
    input logic [1:0]  irq_flags,
    input logic        irq
);
    assert_no_phantom_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[8] && !wr_en |=> stat_word[8]);

    assert_in_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[10] && !irq_clr[1] |=> stat_word[10]);

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && stat_word[16] |-> rd_data == 32'h0);

    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[17] && !rd_en |=> stat_word[17]);

    assert_done_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flags[0]) |-> stat_word[17]);

    assert_done_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flags[0] && !irq_clr[0] |=> irq_flags[0]);

    assert_quiet_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flags == 2'b00 |-> !irq);
endmodule

bind wordport_cbuf wcb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .rd_data(rd_data), .stat_word(stat_word), .irq_clr(irq_clr),
    .irq_flags(irq_flags), .irq(irq)
);

// File: tb/sim_wordport_cbuf.sv
module sim_wordport_cbuf;
    localparam logic [127:0] TB_MASK = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, in_swap = 1'b0, out_swap = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  irq_en = '0, irq_clr = '0;
    logic [31:0] rd_data, stat_word;
    logic [1:0]  irq_flags;
    logic        irq;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wordport_cbuf #(.WORDS(4), .LAT(3), .MASK(TB_MASK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .in_swap(in_swap), .rd_en(rd_en), .rd_data(rd_data),
        .out_swap(out_swap), .irq_en(irq_en), .irq_clr(irq_clr),
        .stat_word(stat_word), .irq_flags(irq_flags), .irq(irq)
    );

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cpu_read(output logic [31:0] r);
        @(negedge clk); rd_en = 1'b1; #1 r = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] b);
        @(negedge clk); irq_clr = b;
        @(negedge clk); irq_clr = 2'b00;
    endtask

    task automatic wait_out_full();
        for (int i = 0; i < 60 && !stat_word[17]; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] pat_word(input int p, input int i);
        return (32'h0102_0304 * (p + 1)) ^ (32'h1111_1111 * (i + 3)) ^ (p << 24);
    endfunction

    task automatic write_block(input int p);
        for (int i = 0; i < 4; i++) cpu_write(pat_word(p, i));
    endtask

    task automatic read_and_check(input int p, input string req);
        logic [31:0] r, e;
        for (int i = 0; i < 4; i++) begin
            cpu_read(r);
            e = (in_swap ? rev(pat_word(p, i)) : pat_word(p, i)) ^ TB_MASK[32*i +: 32];
            if (out_swap) e = rev(e);
            check(r == e, req, r, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(stat_word == 32'h0001_0100, "R1 status", stat_word, 32'h0001_0100);
        check({30'b0, irq_flags} == 0 && !irq, "R1 flags", {29'b0, irq, irq_flags}, 32'h0);

        // R2: three words never reach the engine
        for (int i = 0; i < 3; i++) cpu_write(pat_word(40, i));
        repeat (20) @(negedge clk);
        check(stat_word == 32'h0001_0000, "R2 partial block held", stat_word, 32'h0001_0000);
        cpu_write(pat_word(40, 3));
        check(stat_word[9] && !stat_word[8], "R2 full after four", stat_word, 32'h200);
        wait_out_full();
        // R8 finish flag with deposit
        check(irq_flags[0] == 1'b1, "R8 finish flag", {30'b0, irq_flags}, 32'h1);
        check(stat_word[8], "R2 empty after take", stat_word, 32'h100);
        check(stat_word[17] && !stat_word[16], "R4 output full", stat_word, 32'h20000);
        read_and_check(40, "R4 low word first");
        check(stat_word[16] && !stat_word[17], "R4 output empty", stat_word, 32'h10000);

        // R7: sweep over swap settings and patterns
        for (int sw = 0; sw < 4; sw++) begin
            for (int p = 0; p < 6; p++) begin
                in_swap = sw[0]; out_swap = sw[1];
                write_block(p);
                wait_out_full();
                read_and_check(p, "R7 swap sweep");
            end
        end
        in_swap = 1'b0; out_swap = 1'b0;

        // R6 and R3: three blocks in flight, overrun discarded
        write_block(10);
        wait_out_full();
        write_block(11);
        repeat (20) @(negedge clk);
        write_block(12);
        repeat (10) @(negedge clk);
        check(stat_word[17] && stat_word[9], "R6 stall holds both", stat_word, 32'h20200);
        check(irq_flags[1] == 1'b0, "R3 no error before overrun", {30'b0, irq_flags}, 32'h0);
        cpu_write(32'hDEAD_BEEF);
        check(stat_word[10] == 1'b1, "R3 input error bit", stat_word, 32'h400);
        check(irq_flags[1] == 1'b1, "R9 error flag on overrun", {30'b0, irq_flags}, 32'h2);
        read_and_check(10, "R6 first block intact");
        wait_out_full();
        read_and_check(11, "R6 parked block intact");
        wait_out_full();
        read_and_check(12, "R3 overrun word discarded");

        // R5 underrun
        @(negedge clk);
        check(stat_word[16], "R5 precondition empty", stat_word, 32'h10000);
        cpu_read(r);
        check(r == 32'h0, "R5 empty read zero", r, 32'h0);
        check(stat_word[18] == 1'b1, "R5 output error bit", stat_word, 32'h40000);

        // R9 write-one-to-clear
        pulse_clr(2'b00);
        check(irq_flags == 2'b11, "R9 zero write no effect", {30'b0, irq_flags}, 32'h3);
        pulse_clr(2'b10);
        check(irq_flags == 2'b01, "R9 clear error flag", {30'b0, irq_flags}, 32'h1);
        check(stat_word[10] == 1'b0 && stat_word[18] == 1'b0, "R9 sticky bits cleared", stat_word, 32'h10100);

        // R10 interrupt line
        irq_en = 2'b00; @(negedge clk);
        check(irq == 1'b0, "R10 no enables", {31'b0, irq}, 32'h0);
        irq_en = 2'b01; @(negedge clk);
        check(irq == 1'b1, "R10 finish enabled", {31'b0, irq}, 32'h1);
        irq_en = 2'b10; @(negedge clk);
        check(irq == 1'b0, "R10 error enabled none set", {31'b0, irq}, 32'h0);
        cpu_read(r);
        check(irq == 1'b1, "R10 error raises line", {31'b0, irq}, 32'h1);
        pulse_clr(2'b01);
        check(irq_flags == 2'b10 && irq, "R9 clear finish only", {29'b0, irq, irq_flags}, 32'h6);
        pulse_clr(2'b10);
        check(irq == 1'b0 && irq_flags == 2'b00, "R10 all cleared", {29'b0, irq, irq_flags}, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule